// File: doc/BRIEF.md
# Two-Level Aperture Address Translator

This block turns an offset inside a graphics aperture into a physical memory address. It walks a two-level table to do it. The first level is a directory of 64 entries held on chip. Software fills the directory one entry at a time by writing a single packed 32-bit word. Each entry gives the physical base of a second-level page in system memory. That page holds 1024 four-byte entries, so one directory entry spans 4 MB of aperture.

On a translation request the block checks the offset against the selected aperture size and looks up the directory. It then reads one second-level entry through a simple request/response memory read port. It answers with a one-cycle done pulse that carries either the physical address or a fault. A single-entry translation cache remembers the last successful page. The cache is dropped when any directory word is written, or when a two-word control sequence is written.

The register port has two targets, chosen by `reg_sel`. When `reg_sel` = 0 the write loads the directory. When `reg_sel` = 1 the write goes to the control register.

Top module: `apt_xlate_top`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_done` is 0 and `mem_rd_req` is 0, and every directory entry is absent.
- R2: A directory-load word places the directory index in bits 5:0, the present flag in bit 8 and the second-level page base in bits 31:12. Bits 11:9 (attribute) and bits 7:6 (reserved) have no effect on any translation.
- R3: A directory-load word with bit 8 clear marks that entry absent. A request that falls in an absent entry completes with a fault and issues no memory read.
- R4: For a walk, the directory index is offset bits 31:22 and the second-level index is offset bits 21:12. The memory read address is the entry's page base plus four times the second-level index.
- R5: A second-level entry is usable only when its bit 0 is 1. The answer is then entry bits 31:12 joined with offset bits 11:0. If bit 0 is 0, the answer is a fault. `rsp_done` rises one cycle after the memory response is accepted.
- R6: Size codes 0, 32, 48 and 56 select apertures of 256, 128, 64 and 32 MB (64, 32, 16 and 8 directory entries). Any other code makes every request fault. An offset at or above the aperture size faults, and this check takes priority over a cache hit.
- R7: A fault answer has `rsp_fault` = 1 and `rsp_addr` = 0. A fault found without a walk appears one cycle after acceptance.
- R8: A request in the same 4 KB page as the last successful translation is answered one cycle after acceptance from the cache, with no memory read.
- R9: A control write of 0x2200 followed directly by a control write of 0x2280 empties the cache. A lone 0x2280, or 0x2200 followed by any other value, leaves it intact.
- R10: Any directory-load write empties the cache. This includes a write made while a walk is in flight, whose result is then not cached.
- R11: Requests are taken only while `req_ready` is 1. `rsp_done` lasts exactly one cycle and is followed by `req_ready` = 1. `mem_rd_addr` stays stable while `mem_rd_req` waits for a response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Translation request strobe |
| req_addr | input | 32 | Aperture offset to translate |
| req_ready | output | 1 | Block is idle and takes a request |
| size_code | input | 8 | Aperture size select (0, 32, 48, 56) |
| reg_wr_en | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 = directory-load word, 1 = control register |
| reg_wdata | input | 32 | Register write data |
| mem_rd_req | output | 1 | Second-level read request, held until the response arrives |
| mem_rd_addr | output | 32 | Byte address of the second-level entry |
| mem_rd_resp_valid | input | 1 | Read data valid |
| mem_rd_data | input | 32 | Second-level entry read back |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_fault | output | 1 | Translation failed (valid with `rsp_done`) |
| rsp_addr | output | 32 | Physical address (valid with `rsp_done`, 0 on fault) |

## Verification
The assertions assume the following about the inputs:
- `mem_rd_resp_valid` comes only while `mem_rd_req` is pending, and only for one cycle.
- `size_code` holds steady from request to answer.

The bench's memory responder waits for the request and returns exactly one response pulse after a chosen latency. The bench changes the size code only between transactions, and it drives register writes at negative edges. A directory write that lands in the middle of a walk is made on purpose. That write touches only the register port, which the assertions allow at any time.

// File: rtl/apt_pkg.sv
// Shared widths, entry layout and walker state encoding for the aperture translator.
package apt_pkg;
    localparam int ADDR_W     = 32;
    localparam int PAGE_SHIFT = 12;
    localparam int PPN_W      = ADDR_W - PAGE_SHIFT;

    // Aperture size select codes
    localparam logic [7:0] SZ_CODE_256M = 8'd0;
    localparam logic [7:0] SZ_CODE_128M = 8'd32;
    localparam logic [7:0] SZ_CODE_64M  = 8'd48;
    localparam logic [7:0] SZ_CODE_32M  = 8'd56;

    typedef struct packed {
        logic             present;
        logic [PPN_W-1:0] ppn;
    } dir_entry_t;

    typedef enum logic [1:0] {
        WALK_IDLE = 2'd0,
        WALK_READ = 2'd1,
        WALK_RESP = 2'd2
    } walk_state_e;
endpackage

// File: rtl/apt_dir.sv
// On-chip first-level directory.
// Holds DIR_ENTRIES entries, each a present flag plus a second-level page base.
// A load word is decoded as: index in the low bits, present at bit 8, base in bits 31:12.
// Attribute and reserved bits are discarded.
// Assumes one write per cycle at most; reads are combinational.
module apt_dir
    import apt_pkg::*;
#(
    parameter int DIR_ENTRIES = 64,
    localparam int IDX_W = $clog2(DIR_ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wdata,
    input  logic [IDX_W-1:0]  rd_idx,
    output dir_entry_t        rd_ent
);
    localparam int PRESENT_BIT = 8;

    dir_entry_t       ent_q [DIR_ENTRIES];
    logic [IDX_W-1:0] wr_idx;
    logic             unused_attr;

    assign wr_idx      = wdata[IDX_W-1:0];
    assign unused_attr = ^wdata[PAGE_SHIFT-1:IDX_W];
    assign rd_ent      = ent_q[rd_idx];

    // Clear all entries on reset; otherwise load one entry from the packed word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DIR_ENTRIES; i++) begin
                ent_q[i] <= '0;
            end
        end else if (wr_en) begin
            ent_q[wr_idx] <= '{present: wdata[PRESENT_BIT], ppn: wdata[ADDR_W-1:PAGE_SHIFT]};
        end
    end

    // R3
    absent_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wdata[PRESENT_BIT]) |=> !ent_q[$past(wr_idx)].present);
endmodule

// File: rtl/apt_tcache.sv
// Single-entry translation cache with flush-sequence detection.
// Remembers the last successful virtual page and its physical page.
// Emptied by reset, by any directory write, or by control writes ARM then FIRE back to back.
// Invalidation wins over a fill in the same cycle.
module apt_tcache
    import apt_pkg::*;
#(
    parameter logic [ADDR_W-1:0] FLUSH_ARM  = 32'h0000_2200,
    parameter logic [ADDR_W-1:0] FLUSH_FIRE = 32'h0000_2280
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr,
    input  logic [ADDR_W-1:0] ctrl_data,
    input  logic              dir_wr,
    input  logic              fill_en,
    input  logic [PPN_W-1:0]  fill_vpn,
    input  logic [PPN_W-1:0]  fill_ppn,
    input  logic [PPN_W-1:0]  lk_vpn,
    output logic              hit,
    output logic [PPN_W-1:0]  hit_ppn,
    output logic              inval
);
    logic             armed_q;
    logic             valid_q;
    logic [PPN_W-1:0] vpn_q;
    logic [PPN_W-1:0] ppn_q;
    logic             flush;

    assign flush   = ctrl_wr && armed_q && (ctrl_data == FLUSH_FIRE);
    assign inval   = flush || dir_wr;
    assign hit     = valid_q && (vpn_q == lk_vpn);
    assign hit_ppn = ppn_q;

    // Remember whether the most recent control write was the arming value
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
        end else if (ctrl_wr) begin
            armed_q <= (ctrl_data == FLUSH_ARM);
        end
    end

    // Hold one translation; invalidation has priority over a fill
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            vpn_q   <= '0;
            ppn_q   <= '0;
        end else if (inval) begin
            valid_q <= 1'b0;
        end else if (fill_en) begin
            valid_q <= 1'b1;
            vpn_q   <= fill_vpn;
            ppn_q   <= fill_ppn;
        end
    end

    // R9 R10
    inval_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inval |=> !valid_q);
    // R8
    fill_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_en && !inval) |=> (valid_q && vpn_q == $past(fill_vpn)));
endmodule

// File: rtl/apt_walk.sv
// Request handling and second-level table walk.
// In idle it checks the range, then the cache, then directory presence, and either answers
// directly or issues one memory read. It answers one cycle after the read response.
// Assumes size_code is stable during a request and responses arrive only while a read is pending.
module apt_walk
    import apt_pkg::*;
#(
    parameter int DIR_ENTRIES = 64,
    parameter int L2_ENTRIES  = 1024,
    localparam int L2_W      = $clog2(L2_ENTRIES),
    localparam int DIR_SHIFT = PAGE_SHIFT + L2_W,
    localparam int HI_W      = ADDR_W - DIR_SHIFT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_ready,
    input  logic [7:0]        size_code,
    input  dir_entry_t        dir_ent,
    input  logic              hit,
    input  logic [PPN_W-1:0]  hit_ppn,
    input  logic              inval,
    output logic              mem_rd_req,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic              mem_rd_resp_valid,
    input  logic [ADDR_W-1:0] mem_rd_data,
    output logic              fill_en,
    output logic [PPN_W-1:0]  fill_vpn,
    output logic [PPN_W-1:0]  fill_ppn,
    output logic              rsp_done,
    output logic              rsp_fault,
    output logic [ADDR_W-1:0] rsp_addr
);
    localparam logic [HI_W:0] LIM_256 = (HI_W+1)'(DIR_ENTRIES);
    localparam logic [HI_W:0] LIM_128 = (HI_W+1)'(DIR_ENTRIES / 2);
    localparam logic [HI_W:0] LIM_64  = (HI_W+1)'(DIR_ENTRIES / 4);
    localparam logic [HI_W:0] LIM_32  = (HI_W+1)'(DIR_ENTRIES / 8);

    walk_state_e             state_q;
    logic [HI_W:0]           limit;
    logic                    in_range;
    logic                    accept;
    logic [ADDR_W-1:0]       walk_addr;
    logic [PAGE_SHIFT-1:0]   off_q;
    logic [PPN_W-1:0]        vpn_q;
    logic                    fill_ok_q;
    logic                    unused_rd;

    assign unused_rd = ^mem_rd_data[PAGE_SHIFT-1:1];

    // Map size code to the number of directory entries in use
    always_comb begin
        case (size_code)
            SZ_CODE_256M: limit = LIM_256;
            SZ_CODE_128M: limit = LIM_128;
            SZ_CODE_64M:  limit = LIM_64;
            SZ_CODE_32M:  limit = LIM_32;
            default:      limit = '0;
        endcase
    end

    assign in_range  = {1'b0, req_addr[ADDR_W-1:DIR_SHIFT]} < limit;
    assign req_ready = (state_q == WALK_IDLE);
    assign accept    = req_ready && req_valid;
    assign walk_addr = {dir_ent.ppn, {PAGE_SHIFT{1'b0}}}
                     + {{(ADDR_W-L2_W-2){1'b0}}, req_addr[PAGE_SHIFT +: L2_W], 2'b00};

    assign fill_en  = (state_q == WALK_READ) && mem_rd_resp_valid && mem_rd_data[0]
                      && fill_ok_q && !inval;
    assign fill_vpn = vpn_q;
    assign fill_ppn = mem_rd_data[ADDR_W-1:PAGE_SHIFT];

    // Sequence idle -> (read) -> answer -> idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= WALK_IDLE;
            mem_rd_req  <= 1'b0;
            mem_rd_addr <= '0;
            rsp_done    <= 1'b0;
            rsp_fault   <= 1'b0;
            rsp_addr    <= '0;
            off_q       <= '0;
            vpn_q       <= '0;
            fill_ok_q   <= 1'b0;
        end else begin
            case (state_q)
                WALK_IDLE: begin
                    if (req_valid) begin
                        off_q <= req_addr[PAGE_SHIFT-1:0];
                        vpn_q <= req_addr[ADDR_W-1:PAGE_SHIFT];
                        if (!in_range || (!hit && !dir_ent.present)) begin
                            state_q   <= WALK_RESP;
                            rsp_done  <= 1'b1;
                            rsp_fault <= 1'b1;
                            rsp_addr  <= '0;
                        end else if (hit) begin
                            state_q   <= WALK_RESP;
                            rsp_done  <= 1'b1;
                            rsp_fault <= 1'b0;
                            rsp_addr  <= {hit_ppn, req_addr[PAGE_SHIFT-1:0]};
                        end else begin
                            state_q     <= WALK_READ;
                            mem_rd_req  <= 1'b1;
                            mem_rd_addr <= walk_addr;
                            fill_ok_q   <= !inval;
                        end
                    end
                end
                WALK_READ: begin
                    if (inval) begin
                        fill_ok_q <= 1'b0;
                    end
                    if (mem_rd_resp_valid) begin
                        state_q    <= WALK_RESP;
                        mem_rd_req <= 1'b0;
                        rsp_done   <= 1'b1;
                        if (mem_rd_data[0]) begin
                            rsp_fault <= 1'b0;
                            rsp_addr  <= {mem_rd_data[ADDR_W-1:PAGE_SHIFT], off_q};
                        end else begin
                            rsp_fault <= 1'b1;
                            rsp_addr  <= '0;
                        end
                    end
                end
                WALK_RESP: begin
                    state_q   <= WALK_IDLE;
                    rsp_done  <= 1'b0;
                    rsp_fault <= 1'b0;
                    rsp_addr  <= '0;
                end
                default: state_q <= WALK_IDLE;
            endcase
        end
    end

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> (!rsp_done && req_ready));
    // R11
    rd_addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_req && !mem_rd_resp_valid) |=> (mem_rd_req && $stable(mem_rd_addr)));
    // R11
    resp_only_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_resp_valid |-> mem_rd_req);
    // R7
    fault_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> (rsp_done && rsp_addr == '0));
    // R6
    range_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !in_range) |=> (rsp_done && rsp_fault && !mem_rd_req));
    // R5
    resp_to_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_req && mem_rd_resp_valid) |=> (rsp_done && rsp_fault == !$past(mem_rd_data[0])));
endmodule

// File: rtl/apt_xlate_top.sv
// Two-level aperture address translator top.
// Splits the register port into directory loads and control writes.
// Indexes the directory with the request offset and ties directory, cache and walker together.
// Assumes reg_sel = 0 targets the directory and reg_sel = 1 the control register.
module apt_xlate_top
    import apt_pkg::*;
#(
    parameter int DIR_ENTRIES = 64,
    parameter int L2_ENTRIES  = 1024
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic [31:0] req_addr,
    output logic        req_ready,
    input  logic [7:0]  size_code,
    input  logic        reg_wr_en,
    input  logic        reg_sel,
    input  logic [31:0] reg_wdata,
    output logic        mem_rd_req,
    output logic [31:0] mem_rd_addr,
    input  logic        mem_rd_resp_valid,
    input  logic [31:0] mem_rd_data,
    output logic        rsp_done,
    output logic        rsp_fault,
    output logic [31:0] rsp_addr
);
    localparam int IDX_W     = $clog2(DIR_ENTRIES);
    localparam int DIR_SHIFT = PAGE_SHIFT + $clog2(L2_ENTRIES);

    logic             dir_wr;
    logic             ctrl_wr;
    dir_entry_t       dir_ent;
    logic             hit;
    logic [PPN_W-1:0] hit_ppn;
    logic             inval;
    logic             fill_en;
    logic [PPN_W-1:0] fill_vpn;
    logic [PPN_W-1:0] fill_ppn;

    assign dir_wr  = reg_wr_en && !reg_sel;
    assign ctrl_wr = reg_wr_en && reg_sel;

    apt_dir #(.DIR_ENTRIES(DIR_ENTRIES)) dir_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (dir_wr),
        .wdata  (reg_wdata),
        .rd_idx (req_addr[DIR_SHIFT +: IDX_W]),
        .rd_ent (dir_ent)
    );

    apt_tcache tcache_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl_wr   (ctrl_wr),
        .ctrl_data (reg_wdata),
        .dir_wr    (dir_wr),
        .fill_en   (fill_en),
        .fill_vpn  (fill_vpn),
        .fill_ppn  (fill_ppn),
        .lk_vpn    (req_addr[ADDR_W-1:PAGE_SHIFT]),
        .hit       (hit),
        .hit_ppn   (hit_ppn),
        .inval     (inval)
    );

    apt_walk #(.DIR_ENTRIES(DIR_ENTRIES), .L2_ENTRIES(L2_ENTRIES)) walk_i (
        .clk               (clk),
        .rst_n             (rst_n),
        .req_valid         (req_valid),
        .req_addr          (req_addr),
        .req_ready         (req_ready),
        .size_code         (size_code),
        .dir_ent           (dir_ent),
        .hit               (hit),
        .hit_ppn           (hit_ppn),
        .inval             (inval),
        .mem_rd_req        (mem_rd_req),
        .mem_rd_addr       (mem_rd_addr),
        .mem_rd_resp_valid (mem_rd_resp_valid),
        .mem_rd_data       (mem_rd_data),
        .fill_en           (fill_en),
        .fill_vpn          (fill_vpn),
        .fill_ppn          (fill_ppn),
        .rsp_done          (rsp_done),
        .rsp_fault         (rsp_fault),
        .rsp_addr          (rsp_addr)
    );
endmodule

// File: tb/apt_xlate_top_tb.sv
// Directed bench for the aperture translator: one task per scenario.
module apt_xlate_top_tb_top;
    localparam int K_WALK = 0, K_HIT = 1, K_FAULT = 2, K_WALK_FAULT = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        req_ready;
    logic [7:0]  size_code = 8'd0;
    logic        reg_wr_en = 1'b0;
    logic        reg_sel = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic        mem_rd_req;
    logic [31:0] mem_rd_addr;
    logic        mem_rd_resp_valid = 1'b0;
    logic [31:0] mem_rd_data = '0;
    logic        rsp_done;
    logic        rsp_fault;
    logic [31:0] rsp_addr;

    int          n_tests = 0;
    int          n_fail = 0;
    int          rsp_lat = 0;
    int          rd_count = 0;
    logic [31:0] last_rd_addr = '0;
    logic        mem_clr = 1'b0;
    logic        finished = 1'b0;
    logic [19:0] tb_base [64];

    always #10 clk = ~clk;  // 50 MHz

    apt_xlate_top dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_ready(req_ready), .size_code(size_code), .reg_wr_en(reg_wr_en),
        .reg_sel(reg_sel), .reg_wdata(reg_wdata), .mem_rd_req(mem_rd_req),
        .mem_rd_addr(mem_rd_addr), .mem_rd_resp_valid(mem_rd_resp_valid),
        .mem_rd_data(mem_rd_data), .rsp_done(rsp_done), .rsp_fault(rsp_fault),
        .rsp_addr(rsp_addr)
    );

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        return {a[21:2] ^ 20'h5A5A5, 11'h000, ~mem_clr};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // memory responder: one response pulse rsp_lat cycles after the request is seen
    initial begin
        forever begin
            @(negedge clk);
            if (mem_rd_req) begin
                repeat (rsp_lat) @(negedge clk);
                last_rd_addr = mem_rd_addr;
                rd_count++;
                mem_rd_data = mem_word(mem_rd_addr);
                mem_rd_resp_valid = 1'b1;
                @(negedge clk);
                mem_rd_resp_valid = 1'b0;
            end
        end
    end

    task automatic reg_write(input logic sel, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic load_dir(input int idx, input logic [19:0] base, input logic pres, input logic [5:0] junk);
        reg_write(1'b0, {base, junk[5:3], pres, junk[1:0], 6'(idx)});
        tb_base[idx] = base;
    endtask

    task automatic xlate(input logic [31:0] a, input int kind, input string tag);
        int          cnt;
        int          rd0;
        int          exp_cyc;
        logic [31:0] ra, md, exp_a;
        logic        exp_f;
        rd0 = rd_count;
        ra = {tb_base[a[27:22]], 12'h000} + {20'h0, a[21:12], 2'b00};
        md = mem_word(ra);
        exp_f = (kind == K_FAULT) || (kind == K_WALK_FAULT);
        exp_a = exp_f ? 32'h0 : {md[31:12], a[11:0]};
        exp_cyc = (kind == K_WALK || kind == K_WALK_FAULT) ? rsp_lat + 2 : 1;
        @(negedge clk);
        chk(req_ready, {tag, " ready before request"}, 32'(req_ready), 32'd1);
        req_valid = 1'b1; req_addr = a;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        cnt = 1;
        while (!rsp_done && cnt < 100) begin
            @(negedge clk);
            cnt++;
        end
        chk(cnt == exp_cyc, {tag, " latency"}, 32'(cnt), 32'(exp_cyc));
        chk(rsp_fault == exp_f, {tag, " fault"}, 32'(rsp_fault), 32'(exp_f));
        chk(rsp_addr == exp_a, {tag, " address"}, rsp_addr, exp_a);
        if (kind == K_WALK || kind == K_WALK_FAULT) begin
            chk(rd_count == rd0 + 1, {tag, " one read"}, 32'(rd_count - rd0), 32'd1);
            chk(last_rd_addr == ra, {tag, " R4 read address"}, last_rd_addr, ra);
        end else begin
            chk(rd_count == rd0, {tag, " no read"}, 32'(rd_count - rd0), 32'd0);
        end
        @(negedge clk);
        // R11 one-cycle done, then ready
        chk(!rsp_done && req_ready, {tag, " R11 done pulse"}, {30'h0, rsp_done, req_ready}, 32'd1);
    endtask

    task automatic t_reset();
        chk(req_ready == 1'b1, "R1 ready after reset", 32'(req_ready), 32'd1);
        chk(rsp_done == 1'b0, "R1 done after reset", 32'(rsp_done), 32'd0);
        chk(mem_rd_req == 1'b0, "R1 read req after reset", 32'(mem_rd_req), 32'd0);
        xlate(32'h0000_0000, K_FAULT, "R1 entry absent after reset");
    endtask

    task automatic t_walks();
        load_dir(0, 20'h10000, 1'b1, 6'h00);
        load_dir(5, 20'h20040, 1'b1, 6'h00);
        load_dir(1, 20'h30000, 1'b1, 6'h3F);
        load_dir(7, 20'h41000, 1'b1, 6'h00);
        load_dir(63, 20'h7FFFF, 1'b1, 6'h00);
        rsp_lat = 0;
        xlate(32'h0000_0ABC, K_WALK, "R4 walk entry 0 lat 0");
        xlate(32'h0000_0123, K_HIT, "R8 hit same page");
        rsp_lat = 3;
        xlate(32'h0140_5FF0, K_WALK, "R5 walk entry 5 lat 3");
        xlate(32'h0040_3004, K_WALK, "R2 attribute and reserved bits ignored");
        xlate(32'h0000_1000, K_WALK, "R8 other page walks");
    endtask

    task automatic t_present();
        xlate(32'h0080_0000, K_FAULT, "R3 never loaded entry");
        load_dir(5, 20'h00000, 1'b0, 6'h00);
        xlate(32'h0140_5000, K_FAULT, "R3 index-only write invalidates");
    endtask

    task automatic t_entry_bit0();
        mem_clr = 1'b1;
        xlate(32'h01C0_2000, K_WALK_FAULT, "R5 entry bit0 clear faults");
        mem_clr = 1'b0;
        xlate(32'h01C0_2000, K_WALK, "R7 failed walk not cached");
    endtask

    task automatic t_flush();
        xlate(32'h01C0_2010, K_HIT, "R8 hit after walk");
        reg_write(1'b1, 32'h2280);
        xlate(32'h01C0_2020, K_HIT, "R9 lone fire keeps cache");
        reg_write(1'b1, 32'h2200);
        reg_write(1'b1, 32'h1234);
        reg_write(1'b1, 32'h2280);
        xlate(32'h01C0_2030, K_HIT, "R9 broken sequence keeps cache");
        reg_write(1'b1, 32'h2200);
        reg_write(1'b1, 32'h2280);
        xlate(32'h01C0_2040, K_WALK, "R9 arm then fire flushes");
    endtask

    task automatic t_dir_inval();
        load_dir(9, 20'h55000, 1'b1, 6'h00);
        xlate(32'h01C0_2050, K_WALK, "R10 directory write flushes");
        rsp_lat = 5;
        fork
            xlate(32'h0000_2000, K_WALK, "R10 walk with write in flight");
            begin
                @(negedge clk);
                load_dir(10, 20'h56000, 1'b1, 6'h00);
            end
        join
        rsp_lat = 1;
        xlate(32'h0000_2004, K_WALK, "R10 in-flight result not cached");
        xlate(32'h0000_2008, K_HIT, "R8 cached after clean walk");
    endtask

    task automatic t_sizes();
        rsp_lat = 1;
        size_code = 8'd0;
        xlate(32'h0FFF_F000, K_WALK, "R6 256MB top page");
        xlate(32'h0FFF_F004, K_HIT, "R8 hit top page");
        size_code = 8'd56;
        xlate(32'h0FFF_F008, K_FAULT, "R6 range check beats cache hit");
        xlate(32'h0200_0000, K_FAULT, "R6 32MB limit");
        xlate(32'h01FF_FFFC, K_WALK, "R6 32MB last page");
        size_code = 8'd48;
        xlate(32'h0400_0000, K_FAULT, "R6 64MB limit");
        xlate(32'h01C0_0000, K_WALK, "R6 64MB inside");
        size_code = 8'd32;
        xlate(32'h0800_0000, K_FAULT, "R6 128MB limit");
        xlate(32'h0000_3000, K_WALK, "R6 128MB inside");
        size_code = 8'd5;
        xlate(32'h0000_0000, K_FAULT, "R6 unknown size code");
        size_code = 8'd0;
        xlate(32'h1000_0000, K_FAULT, "R6 256MB limit");
        xlate(32'h0FFF_E000, K_WALK, "R6 256MB inside");
    endtask

    initial begin
        for (int i = 0; i < 64; i++) tb_base[i] = '0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_walks();
        t_present();
        t_entry_bit0();
        t_flush();
        t_dir_inval();
        t_sizes();
        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule